// File: doc/BRIEF.md
# Direct-Mapped Next-PC Predictor

This block guesses the address to fetch after the current one. In the fetch stage it receives the current program counter and returns a predicted next program counter in the same cycle. It looks up a small direct-mapped table using the low PC bits. When the entry is valid and its stored tag equals the upper PC bits, the stored target is returned. In every other case it returns the sequential address, PC plus one. It never looks at instruction bits.

The execute stage corrects the table. When the pipeline finds that the address fetched after an instruction was wrong, it pulses the update enable. With that pulse it supplies the PC of that instruction and the next PC that was actually resolved. The entry at that PC's index is then overwritten: the tag, the target and the valid bit are all written. A mode input forces the plain PC plus one guess. In that mode the table keeps learning in the background, so switching the mode back restores the trained predictions.

Top module: `npc_predictor`

## Requirements
- R1: After reset every entry is invalid, so every lookup returns PC+1 until that PC's index has been written.
- R2: After an update with PC P and target N, a lookup of P (table mode) returns N from the cycle after the update until that entry is overwritten.
- R3: The index is PC[2:0] and the tag is PC[15:3]. A lookup whose index holds a valid entry with a different tag returns PC+1.
- R4: An update replaces both the tag and the target at its index. An earlier PC that maps to the same index then misses.
- R5: An update changes only the entry at its own index. The predictions for the other indices are unchanged.
- R6: A lookup in the same cycle as an update to the same index sees the table contents from before that update.
- R7: While fixed_mode is 1, the output is PC+1 for every PC. Updates made in this mode still train the table, and they are visible once fixed_mode returns to 0.
- R8: PC+1 wraps modulo 2^16, so a miss at 0xFFFF predicts 0x0000.
- R9: While upd_en is 0, the update PC and target inputs have no effect on any later prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears all valid bits |
| fixed_mode | input | 1 | 1 = always predict PC+1; 0 = use the table |
| look_pc | input | 16 | Fetch-stage PC to predict from |
| pred_pc | output | 16 | Predicted next PC (combinational) |
| upd_en | input | 1 | Write strobe, asserted on a mispredict |
| upd_pc | input | 16 | PC of the execute-stage instruction |
| upd_next | input | 16 | Resolved next PC of that instruction |

## Verification
Lookups of untouched PCs right after reset distinguish cleared valid bits from stale contents. Trained PCs are probed alongside PCs that share their index but differ in the upper bits, which separates a true tag compare from an index-only hit. Same-cycle update and lookup on one index shows whether the read happens before the write. Toggling the mode around updates shows whether fixed mode only masks the output or also blocks learning. A long pseudo-random stream confined to a few tags mixes hits, conflicts and idle updates, and is compared each cycle against a behavioural table model.

// File: rtl/npc_pkg.sv
package npc_pkg;
    localparam int DEF_PC_W    = 16;
    localparam int DEF_ENTRIES = 8;

    typedef enum logic {
        SRC_SEQ   = 1'b0,
        SRC_TABLE = 1'b1
    } pred_src_e;
endpackage

// File: rtl/npc_field_split.sv
module npc_field_split #(
    parameter int PC_W  = 16,
    parameter int IDX_W = 3,
    localparam int TAG_W = PC_W - IDX_W
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag
);
    assign idx = pc[IDX_W-1:0];
    assign tag = pc[PC_W-1:IDX_W];
endmodule

// File: rtl/npc_table.sv
module npc_table #(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 13,
    parameter int PC_W    = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [PC_W-1:0]  wr_tgt,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             hit,
    output logic [PC_W-1:0]  rd_tgt
);
    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [PC_W-1:0]    tgt_q [ENTRIES];
    logic [ENTRIES-1:0] entry_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
            tag_q[wr_idx]   <= wr_tag;
            tgt_q[wr_idx]   <= wr_tgt;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_match
        assign entry_hit[g] = valid_q[g] && (rd_idx == IDX_W'(g)) && (tag_q[g] == rd_tag);
    end

    always_comb begin
        rd_tgt = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (entry_hit[i]) rd_tgt = rd_tgt | tgt_q[i];
        end
    end

    assign hit = |entry_hit;

    // R1: reset leaves every entry invalid
    a_r1_clear_on_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (valid_q == '0));

    // R9: no strobe, no change to the valid set
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(valid_q));

    // R2: a written entry becomes valid
    a_r2_write_sets_valid: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> valid_q[$past(wr_idx)]);

    // R3: at most one entry can match a lookup
    a_r3_single_match: assert property (@(posedge clk) disable iff (rst)
        $onehot0(entry_hit));
endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic            fixed_mode,
    input  logic            hit,
    input  logic [PC_W-1:0] pc,
    input  logic [PC_W-1:0] tgt,
    output logic [PC_W-1:0] pred
);
    pred_src_e src;

    always_comb begin
        src = (hit && !fixed_mode) ? SRC_TABLE : SRC_SEQ;
        unique case (src)
            SRC_TABLE: pred = tgt;
            default:   pred = pc + PC_W'(1);
        endcase
    end

    // R8: sequential guess at the top address wraps to zero
    a_r8_wrap: assert final ((src != SRC_SEQ) || (pc != '1) || (pred == '0));
endmodule

// File: rtl/npc_predictor.sv
module npc_predictor
    import npc_pkg::*;
#(
    parameter int PC_W    = DEF_PC_W,
    parameter int ENTRIES = DEF_ENTRIES,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int TAG_W  = PC_W - IDX_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fixed_mode,
    input  logic [PC_W-1:0] look_pc,
    output logic [PC_W-1:0] pred_pc,
    input  logic            upd_en,
    input  logic [PC_W-1:0] upd_pc,
    input  logic [PC_W-1:0] upd_next
);
    logic [IDX_W-1:0] rd_idx, wr_idx;
    logic [TAG_W-1:0] rd_tag, wr_tag;
    logic             hit;
    logic [PC_W-1:0]  tbl_tgt;

    npc_field_split #(.PC_W(PC_W), .IDX_W(IDX_W)) u_split_rd (
        .pc(look_pc), .idx(rd_idx), .tag(rd_tag)
    );

    npc_field_split #(.PC_W(PC_W), .IDX_W(IDX_W)) u_split_wr (
        .pc(upd_pc), .idx(wr_idx), .tag(wr_tag)
    );

    npc_table #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .PC_W(PC_W)) u_table (
        .clk(clk), .rst(rst),
        .wr_en(upd_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_tgt(upd_next),
        .rd_idx(rd_idx), .rd_tag(rd_tag), .hit(hit), .rd_tgt(tbl_tgt)
    );

    npc_select #(.PC_W(PC_W)) u_select (
        .fixed_mode(fixed_mode), .hit(hit), .pc(look_pc), .tgt(tbl_tgt), .pred(pred_pc)
    );

    // R2: the cycle after an update, looking up the same PC in table mode yields its target
    a_r2_learned_target: assert property (@(posedge clk) disable iff (rst)
        upd_en |=> (fixed_mode || (look_pc != $past(upd_pc)) || (pred_pc == $past(upd_next))));

    // R7: fixed mode always gives the sequential address
    a_r7_fixed_seq: assert property (@(posedge clk) disable iff (rst)
        fixed_mode |-> (pred_pc == look_pc + PC_W'(1)));
endmodule

// File: tb/npc_predictor_bench.sv
module npc_predictor_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fixed_mode = 1'b0;
    logic [15:0] look_pc = '0;
    logic [15:0] pred_pc;
    logic        upd_en = 1'b0;
    logic [15:0] upd_pc = '0;
    logic [15:0] upd_next = '0;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    int m_valid [8];
    int m_tag   [8];
    int m_tgt   [8];

    always #5 clk = ~clk;

    npc_predictor u_npc_predictor (
        .clk(clk), .rst(rst), .fixed_mode(fixed_mode), .look_pc(look_pc),
        .pred_pc(pred_pc), .upd_en(upd_en), .upd_pc(upd_pc), .upd_next(upd_next)
    );

    function automatic int model_pred(int pc, bit mode);
        int slot = pc % 8;
        if (!mode && m_valid[slot] != 0 && m_tag[slot] == pc / 8) return m_tgt[slot];
        return (pc + 1) % 65536;
    endfunction

    task automatic step(string req, bit mode, int look, bit en, int upc, int unext);
        int exp;
        @(negedge clk);
        fixed_mode = mode;
        look_pc = 16'(look);
        upd_en = en;
        upd_pc = 16'(upc);
        upd_next = 16'(unext);
        #1;
        exp = model_pred(look, mode);
        tests++;
        if (int'(pred_pc) != exp) begin
            fails++;
            $display("FAIL %s look=%h actual=%h expected=%h", req, look, pred_pc, exp[15:0]);
        end
        @(posedge clk);
        if (en) begin
            m_valid[upc % 8] = 1;
            m_tag[upc % 8] = upc / 8;
            m_tgt[upc % 8] = unext;
        end
    endtask

    initial begin
        int lfsr = 16'hACE1;
        for (int i = 0; i < 8; i++) begin
            m_valid[i] = 0; m_tag[i] = 0; m_tgt[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: cleared table
        step("R1", 0, 16'h0000, 0, 0, 0);
        step("R1", 0, 16'h1234, 0, 0, 0);
        step("R1", 0, 16'h8007, 0, 0, 0);
        // R2: train and hit
        step("R2", 0, 16'h0100, 1, 16'h1234, 16'h2000);
        step("R2", 0, 16'h1234, 0, 0, 0);
        // R3: same index, other tag
        step("R3", 0, 16'h123C, 0, 0, 0);
        step("R3", 0, 16'hF234 & 16'hFFF4 | 16'h0004, 0, 0, 0);
        // R6: lookup during same-index update sees old, then new
        step("R6", 0, 16'h1234, 1, 16'h1234, 16'h3000);
        step("R6", 0, 16'h1234, 0, 0, 0);
        // R4: conflicting update evicts
        step("R4", 0, 16'h0000, 1, 16'h123C, 16'h4444);
        step("R4", 0, 16'h1234, 0, 0, 0);
        step("R4", 0, 16'h123C, 0, 0, 0);
        // R5: fill all indices, then probe each
        for (int k = 0; k < 8; k++) step("R5", 0, 16'h0040, 1, 16'h0500 + k, 16'h0A00 + 3 * k);
        for (int k = 0; k < 8; k++) step("R5", 0, 16'h0500 + k, 0, 0, 0);
        step("R5", 0, 16'h0507, 1, 16'h0502, 16'h7777);
        for (int k = 0; k < 8; k++) step("R5", 0, 16'h0500 + k, 0, 0, 0);
        // R9: idle update inputs
        step("R9", 0, 16'h0503, 0, 16'h0503, 16'hDEAD);
        step("R9", 0, 16'h0503, 0, 16'h9993, 16'hBEEF);
        step("R9", 0, 16'h9993, 0, 0, 0);
        // R7: fixed mode masks, still trains
        step("R7", 1, 16'h0501, 0, 0, 0);
        step("R7", 1, 16'h0504, 1, 16'h0504, 16'h5555);
        step("R7", 1, 16'h0504, 0, 0, 0);
        step("R7", 0, 16'h0504, 0, 0, 0);
        // R8: wrap
        step("R8", 0, 16'hFFFF, 0, 0, 0);
        step("R8", 1, 16'hFFFF, 1, 16'hFFFF, 16'h0010);
        step("R8", 0, 16'hFFFF, 0, 0, 0);
        step("R8", 1, 16'hFFFF, 0, 0, 0);
        // R2: random mix over a few tags
        for (int n = 0; n < 400; n++) begin
            int a, b;
            lfsr = ((lfsr << 1) | (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1)) & 16'hFFFF;
            a = 16'h2000 + (lfsr & 16'h001F);
            b = 16'h2000 + ((lfsr >> 5) & 16'h001F);
            step("R2", (lfsr >> 11) % 8 == 0, a, (lfsr >> 14) & 1, b, lfsr ^ 16'h5A5A);
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            #2000000;
        join_any
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule